// File: doc/BRIEF.md
# Multi-Mode Raster Timing Generator

This block produces the horizontal and vertical scan timing for an analogue VGA display from a single pixel clock. One counter tracks the column within a line and a second tracks the line within a frame. Each axis cycles through four phases in a fixed order: visible pixels, a front porch, a sync pulse and a back porch. From these two counters the block decodes both sync pulses (active low), a blanking signal, a data-enable flag and the visible column and row. A colour word supplied by the pixel source passes to the colour outputs during the visible area. Outside that area the colour outputs are forced to black.

Three timing sets are held in a parameter table, and a two-bit selector picks one of them while the block runs. The block samples the selector only at the instant the last pixel of a frame wraps to the first. A change therefore never shortens or stretches a frame already under way, and the new frame starts from column 0, row 0. All outputs leave one register stage together, so sync, blanking, position and colour describe the same pixel. The composite-sync output is tied high.

Top module: `vga_timing_gen`

## Requirements
- R1: Each line is h_act visible pixels, then h_fp, then h_sync, then h_bp clocks. hsync_o is low exactly for columns h_act+h_fp to h_act+h_fp+h_sync-1 and high otherwise. The line length is the sum of the four phases: 800 / 1056 / 1344 for the three standard sets.
- R2: The row counter advances only when the column wraps from its last value to 0. vsync_o is low exactly for rows v_act+v_fp to v_act+v_fp+v_sync-1, and a frame holds v_act+v_fp+v_sync+v_bp lines: 525 / 628 / 806.
- R3: Mode code 0 selects 640x480 (h 640/16/96/48, v 480/10/2/33). Code 1 selects 800x600 (h 800/40/128/88, v 600/1/4/23). Code 2 selects 1024x768 (h 1024/24/136/160, v 768/3/6/29). Code 3 is treated as code 0.
- R4: mode_i is sampled only on the clock edge where both counters wrap at the end of a frame. Changes during a frame have no effect on that frame, and the next frame starts at column 0, row 0 in the new mode.
- R5: de_o is 1 exactly when column < h_act and row < v_act. blank_no equals de_o: 0 while blanking, 1 while visible.
- R6: While de_o is 1, col_o and row_o give the visible column and row. While de_o is 0, both are 0.
- R7: rgb_o equals the pix_rgb_i value present at the clock edge that produced the pixel when de_o is 1, and 0 otherwise.
- R8: csync_no is constant 1.
- R9: While rst_ni is low, both counters are 0 and the mode loads RESET_MODE (default code 0). hsync_o and vsync_o are 1; de_o, blank_no, col_o, row_o and rgb_o are 0. The first edge after release outputs pixel (0,0).
- R10: All timing, position and colour outputs are registered and describe the counter position present before the same clock edge (one cycle latency), so they stay mutually aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode code, applied at the next frame boundary |
| pix_rgb_i | input | 3*COLOR_W | Colour word for the current pixel, red in the top bits |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_no | output | 1 | 0 while blanking, 1 while visible |
| csync_no | output | 1 | Composite sync, held at 1 |
| de_o | output | 1 | Visible-pixel flag |
| col_o | output | TW | Visible column, 0 outside the visible area |
| row_o | output | TW | Visible row, 0 outside the visible area |
| rgb_o | output | 3*COLOR_W | Colour output, black outside the visible area |

## Verification
The main function is checked cycle by cycle against a bench model on four instances. Three instances use the standard tables in modes 0, 1 and 2 for several full lines; these runs separate the three horizontal phase sets and confirm the row step at each line wrap. One instance uses shrunken tables, so whole frames run quickly. On it the mode selector is changed mid-frame, toggled several times within one frame, and set to code 3; only a boundary-sampled selector reproduces the expected frame lengths. Colour input is driven as an incrementing count, all ones and an alternating pattern. This separates a pass-through that is masked and delayed by exactly one cycle from one that is stale, unmasked or stuck.

// File: rtl/vga_pkg.sv
package vga_pkg;
  localparam int unsigned TW = 11;
  typedef logic [TW-1:0] len_t;

  typedef struct packed {
    len_t h_act;
    len_t h_fp;
    len_t h_sync;
    len_t h_bp;
    len_t v_act;
    len_t v_fp;
    len_t v_sync;
    len_t v_bp;
  } timing_t;

  typedef timing_t [2:0] timing_tab_t;

  localparam timing_t T_640 = '{h_act: 11'd640,  h_fp: 11'd16, h_sync: 11'd96,  h_bp: 11'd48,
                                v_act: 11'd480,  v_fp: 11'd10, v_sync: 11'd2,   v_bp: 11'd33};
  localparam timing_t T_800 = '{h_act: 11'd800,  h_fp: 11'd40, h_sync: 11'd128, h_bp: 11'd88,
                                v_act: 11'd600,  v_fp: 11'd1,  v_sync: 11'd4,   v_bp: 11'd23};
  localparam timing_t T_1024 = '{h_act: 11'd1024, h_fp: 11'd24, h_sync: 11'd136, h_bp: 11'd160,
                                 v_act: 11'd768,  v_fp: 11'd3,  v_sync: 11'd6,   v_bp: 11'd29};

  localparam timing_tab_t STD_TAB = {T_1024, T_800, T_640};

  // code 3 has no table entry of its own
  function automatic logic [1:0] mode_index(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd0 : sel;
  endfunction
endpackage

// File: rtl/vga_axis_ctr.sv
module vga_axis_ctr #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] fp_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] bp_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         active_o,
  output logic         sync_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] sync_beg;
  logic [W-1:0] sync_end;
  logic [W-1:0] last_val;

  assign sync_beg = act_i + fp_i;
  assign sync_end = sync_beg + sync_i;
  assign last_val = sync_end + bp_i - ONE;

  assign last_o   = (cnt_q == last_val);
  assign active_o = (cnt_q < act_i);
  assign sync_o   = (cnt_q >= sync_beg) && (cnt_q < sync_end);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + ONE;
    end
  end
endmodule

// File: rtl/vga_mode_sel.sv
module vga_mode_sel #(
  parameter logic [1:0] RESET_MODE = 2'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_end_i,
  input  logic [1:0] mode_i,
  output logic [1:0] mode_o
);
  logic [1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= vga_pkg::mode_index(RESET_MODE);
    end else if (frame_end_i) begin
      mode_q <= vga_pkg::mode_index(mode_i);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vga_out_reg.sv
module vga_out_reg #(
  parameter int unsigned COLOR_W = 8,
  parameter int unsigned TW      = 11,
  localparam int unsigned PW     = 3 * COLOR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_act_i,
  input  logic          v_act_i,
  input  logic          h_sync_i,
  input  logic          v_sync_i,
  input  logic [TW-1:0] col_i,
  input  logic [TW-1:0] row_i,
  input  logic [PW-1:0] pix_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_no,
  output logic          de_o,
  output logic [TW-1:0] col_o,
  output logic [TW-1:0] row_o,
  output logic [PW-1:0] rgb_o
);
  logic vis;
  assign vis = h_act_i & v_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b1;
      blank_no <= 1'b0;
      de_o     <= 1'b0;
      col_o    <= '0;
      row_o    <= '0;
      rgb_o    <= '0;
    end else begin
      hsync_o  <= ~h_sync_i;
      vsync_o  <= ~v_sync_i;
      blank_no <= vis;
      de_o     <= vis;
      col_o    <= vis ? col_i : '0;
      row_o    <= vis ? row_i : '0;
      rgb_o    <= vis ? pix_i : '0;
    end
  end
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
  import vga_pkg::*;
#(
  parameter int unsigned COLOR_W    = 8,
  parameter logic [1:0]  RESET_MODE = 2'd0,
  parameter timing_tab_t TAB        = STD_TAB,
  localparam int unsigned PW        = 3 * COLOR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] pix_rgb_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_no,
  output logic          csync_no,
  output logic          de_o,
  output logic [TW-1:0] col_o,
  output logic [TW-1:0] row_o,
  output logic [PW-1:0] rgb_o
);
  logic [1:0]    mode_q;
  timing_t       cur_t;
  logic [TW-1:0] h_cnt, v_cnt;
  logic          h_last, v_last, h_act, v_act, h_sync, v_sync;
  logic          frame_end;

  assign cur_t     = TAB[mode_q];
  assign frame_end = h_last & v_last;

  vga_mode_sel #(.RESET_MODE(RESET_MODE)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .mode_i      (mode_i),
    .mode_o      (mode_q)
  );

  vga_axis_ctr #(.W(TW)) u_hctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (1'b1),
    .act_i    (cur_t.h_act),
    .fp_i     (cur_t.h_fp),
    .sync_i   (cur_t.h_sync),
    .bp_i     (cur_t.h_bp),
    .cnt_o    (h_cnt),
    .last_o   (h_last),
    .active_o (h_act),
    .sync_o   (h_sync)
  );

  vga_axis_ctr #(.W(TW)) u_vctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (h_last),
    .act_i    (cur_t.v_act),
    .fp_i     (cur_t.v_fp),
    .sync_i   (cur_t.v_sync),
    .bp_i     (cur_t.v_bp),
    .cnt_o    (v_cnt),
    .last_o   (v_last),
    .active_o (v_act),
    .sync_o   (v_sync)
  );

  vga_out_reg #(.COLOR_W(COLOR_W), .TW(TW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_act_i  (h_act),
    .v_act_i  (v_act),
    .h_sync_i (h_sync),
    .v_sync_i (v_sync),
    .col_i    (h_cnt),
    .row_i    (v_cnt),
    .pix_i    (pix_rgb_i),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .blank_no (blank_no),
    .de_o     (de_o),
    .col_o    (col_o),
    .row_o    (row_o),
    .rgb_o    (rgb_o)
  );

  assign csync_no = 1'b1;
endmodule

// File: rtl/vga_timing_chk.sv
module vga_timing_chk #(
  parameter int unsigned COLOR_W = 8,
  parameter int unsigned TW      = 11,
  localparam int unsigned PW     = 3 * COLOR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] pix_rgb_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          blank_no,
  input logic          csync_no,
  input logic          de_o,
  input logic [TW-1:0] col_o,
  input logic [TW-1:0] row_o,
  input logic [PW-1:0] rgb_o
);
  AST_CSYNC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csync_no); // R8
  AST_BLANK_TRACKS_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_no == de_o); // R5
  AST_HSYNC_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !de_o); // R1
  AST_VSYNC_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> !de_o); // R2
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o && $past(de_o) |-> col_o == $past(col_o) + TW'(1)); // R6
  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o && $past(de_o) |-> row_o == $past(row_o)); // R2
  AST_RGB_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> rgb_o == '0); // R7
  AST_RGB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> rgb_o == $past(pix_rgb_i)); // R7
endmodule

bind vga_timing_gen vga_timing_chk #(.COLOR_W(COLOR_W), .TW(vga_pkg::TW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_rgb_i (pix_rgb_i),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .blank_no  (blank_no),
  .csync_no  (csync_no),
  .de_o      (de_o),
  .col_o     (col_o),
  .row_o     (row_o),
  .rgb_o     (rgb_o)
);

// File: tb/sim_vga_timing_gen.sv
`timescale 1ns/1ps
module sim_vga_timing_gen;
  import vga_pkg::*;

  localparam int CW   = 8;
  localparam int PW   = 3 * CW;
  localparam int NI   = 4;
  localparam int WD_NS = 4_000_000; // 200k cycles at 20 ns

  localparam timing_t S0 = '{h_act: 11'd8,  h_fp: 11'd2, h_sync: 11'd3, h_bp: 11'd2,
                             v_act: 11'd4,  v_fp: 11'd1, v_sync: 11'd2, v_bp: 11'd1};
  localparam timing_t S1 = '{h_act: 11'd10, h_fp: 11'd1, h_sync: 11'd2, h_bp: 11'd3,
                             v_act: 11'd5,  v_fp: 11'd2, v_sync: 11'd1, v_bp: 11'd2};
  localparam timing_t S2 = '{h_act: 11'd6,  h_fp: 11'd3, h_sync: 11'd1, h_bp: 11'd1,
                             v_act: 11'd3,  v_fp: 11'd1, v_sync: 11'd1, v_bp: 11'd3};
  localparam timing_tab_t SMALL_TAB = {S2, S1, S0};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_sel = 2'd0;
  logic [PW-1:0] pix = '0;

  logic          hs_w [NI];
  logic          vs_w [NI];
  logic          bl_w [NI];
  logic          cs_w [NI];
  logic          de_w [NI];
  logic [TW-1:0] col_w [NI];
  logic [TW-1:0] row_w [NI];
  logic [PW-1:0] rgb_w [NI];

  int checks = 0;
  int fails  = 0;
  int pat    = 0;
  int pcnt   = 0;
  bit done   = 0;

  int eh [NI];
  int ev [NI];
  int em [NI];

  always #10 clk = ~clk;

  vga_timing_gen #(.COLOR_W(CW), .RESET_MODE(2'd0), .TAB(SMALL_TAB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_sel), .pix_rgb_i(pix),
    .hsync_o(hs_w[0]), .vsync_o(vs_w[0]), .blank_no(bl_w[0]), .csync_no(cs_w[0]),
    .de_o(de_w[0]), .col_o(col_w[0]), .row_o(row_w[0]), .rgb_o(rgb_w[0]));

  // u1..u3 hold the three standard tables (R3)
  vga_timing_gen #(.COLOR_W(CW), .RESET_MODE(2'd0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(2'd0), .pix_rgb_i(pix),
    .hsync_o(hs_w[1]), .vsync_o(vs_w[1]), .blank_no(bl_w[1]), .csync_no(cs_w[1]),
    .de_o(de_w[1]), .col_o(col_w[1]), .row_o(row_w[1]), .rgb_o(rgb_w[1]));

  vga_timing_gen #(.COLOR_W(CW), .RESET_MODE(2'd1)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(2'd1), .pix_rgb_i(pix),
    .hsync_o(hs_w[2]), .vsync_o(vs_w[2]), .blank_no(bl_w[2]), .csync_no(cs_w[2]),
    .de_o(de_w[2]), .col_o(col_w[2]), .row_o(row_w[2]), .rgb_o(rgb_w[2]));

  vga_timing_gen #(.COLOR_W(CW), .RESET_MODE(2'd2)) u3 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(2'd2), .pix_rgb_i(pix),
    .hsync_o(hs_w[3]), .vsync_o(vs_w[3]), .blank_no(bl_w[3]), .csync_no(cs_w[3]),
    .de_o(de_w[3]), .col_o(col_w[3]), .row_o(row_w[3]), .rgb_o(rgb_w[3]));

  // phase lengths: 0 h_act 1 h_fp 2 h_sync 3 h_bp 4 v_act 5 v_fp 6 v_sync 7 v_bp
  function automatic int tlen(input int inst, input int md, input int f);
    int s [8];
    if (inst == 0) begin
      case (md)
        0:       s = '{8, 2, 3, 2, 4, 1, 2, 1};
        1:       s = '{10, 1, 2, 3, 5, 2, 1, 2};
        default: s = '{6, 3, 1, 1, 3, 1, 1, 3};
      endcase
    end else begin
      case (md)
        0:       s = '{640, 16, 96, 48, 480, 10, 2, 33};
        1:       s = '{800, 40, 128, 88, 600, 1, 4, 23};
        default: s = '{1024, 24, 136, 160, 768, 3, 6, 29};
      endcase
    end
    return s[f];
  endfunction

  function automatic int sel_of(input int inst);
    int m;
    m = (inst == 0) ? int'(mode_sel) : inst - 1;
    return (m == 3) ? 0 : m;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin
      eh[i] = 0;
      ev[i] = 0;
      em[i] = (i == 0) ? 0 : i - 1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string tag,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, tag, $time, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] next_pix();
    case (pat)
      0:       return PW'(pcnt * 7 + 1);
      1:       return '1;
      2:       return (pcnt % 2 == 0) ? 24'hAA55AA : 24'h55AA55;
      default: return PW'(pcnt * 40503 + 12345);
    endcase
  endfunction

  task automatic step(input string tag);
    int ch [NI];
    int cv [NI];
    int cm [NI];
    logic [PW-1:0] cp;
    @(posedge clk);
    cp = pix;
    for (int i = 0; i < NI; i++) begin
      int htot, vtot;
      ch[i] = eh[i]; cv[i] = ev[i]; cm[i] = em[i];
      htot = tlen(i, em[i], 0) + tlen(i, em[i], 1) + tlen(i, em[i], 2) + tlen(i, em[i], 3);
      vtot = tlen(i, em[i], 4) + tlen(i, em[i], 5) + tlen(i, em[i], 6) + tlen(i, em[i], 7);
      if (eh[i] == htot - 1) begin
        eh[i] = 0;
        if (ev[i] == vtot - 1) begin
          ev[i] = 0;
          em[i] = sel_of(i);
        end else begin
          ev[i] = ev[i] + 1;
        end
      end else begin
        eh[i] = eh[i] + 1;
      end
    end
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      int ha, hf, hsn, va, vf, vsn;
      bit e_de, e_hs, e_vs;
      ha = tlen(i, cm[i], 0); hf = tlen(i, cm[i], 1); hsn = tlen(i, cm[i], 2);
      va = tlen(i, cm[i], 4); vf = tlen(i, cm[i], 5); vsn = tlen(i, cm[i], 6);
      e_de = (ch[i] < ha) && (cv[i] < va);
      e_hs = !((ch[i] >= ha + hf) && (ch[i] < ha + hf + hsn));
      e_vs = !((cv[i] >= va + vf) && (cv[i] < va + vf + vsn));
      chk(hs_w[i] == e_hs, "R1", tag, hs_w[i], e_hs);
      chk(vs_w[i] == e_vs, "R2", tag, vs_w[i], e_vs);
      chk(de_w[i] == e_de, "R5", tag, de_w[i], e_de);
      chk(bl_w[i] == e_de, "R5", tag, bl_w[i], e_de);
      chk(col_w[i] == (e_de ? TW'(ch[i]) : '0), "R6", tag, col_w[i], e_de ? ch[i] : 0);
      chk(row_w[i] == (e_de ? TW'(cv[i]) : '0), "R6", tag, row_w[i], e_de ? cv[i] : 0);
      chk(rgb_w[i] == (e_de ? cp : '0), "R7", tag, rgb_w[i], e_de ? cp : 0);
      chk(cs_w[i] == 1'b1, "R8", tag, cs_w[i], 1);
    end
    pcnt++;
    pix = next_pix();
  endtask

  task automatic check_idle(input string tag);
    for (int i = 0; i < NI; i++) begin
      chk(hs_w[i] == 1'b1, "R9", tag, hs_w[i], 1);
      chk(vs_w[i] == 1'b1, "R9", tag, vs_w[i], 1);
      chk(de_w[i] == 1'b0, "R9", tag, de_w[i], 0);
      chk(bl_w[i] == 1'b0, "R9", tag, bl_w[i], 0);
      chk(col_w[i] == '0 && row_w[i] == '0, "R9", tag, {col_w[i], row_w[i]}, 0);
      chk(rgb_w[i] == '0, "R9", tag, rgb_w[i], 0);
      chk(cs_w[i] == 1'b1, "R8", tag, cs_w[i], 1);
    end
  endtask

  // R9: idle outputs during reset, pixel (0,0) first after release
  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R9 reset");
    model_reset();
    rst_ni = 1'b1;
    step("R9 first pixel");
  endtask

  // R1 R3 R10: full standard lines in all three modes
  task automatic t_real_lines();
    pat = 0;
    for (int n = 0; n < 2 * 1344 + 200; n++) step("R1 R3 R10 lines");
  endtask

  // R2 R5 R7: whole frames on shrunken tables, varied colour
  task automatic t_small_frames();
    pat = 1;
    for (int n = 0; n < 240; n++) step("R2 R5 frames ones");
    pat = 2;
    for (int n = 0; n < 240; n++) step("R7 frames alt");
  endtask

  // R4: selector changes inside a frame only land at the boundary
  task automatic t_mode_midframe();
    pat = 3;
    for (int n = 0; n < 37; n++) step("R4 pre");
    mode_sel = 2'd1;
    for (int n = 0; n < 400; n++) step("R4 switch to 1");
    mode_sel = 2'd2;
    for (int n = 0; n < 20; n++) step("R4 toggle");
    mode_sel = 2'd0;
    for (int n = 0; n < 20; n++) step("R4 toggle");
    mode_sel = 2'd2;
    for (int n = 0; n < 400; n++) step("R4 switch to 2");
  endtask

  // R3: code 3 behaves as code 0
  task automatic t_mode_three();
    mode_sel = 2'd3;
    for (int n = 0; n < 400; n++) step("R3 code3");
  endtask

  // R9: reset in mid-frame restarts at (0,0) in the reset mode
  task automatic t_reset_mid();
    mode_sel = 2'd1;
    for (int n = 0; n < 53; n++) step("R9 pre-reset");
    rst_ni = 1'b0;
    @(negedge clk);
    check_idle("R9 mid reset");
    model_reset();
    rst_ni = 1'b1;
    for (int n = 0; n < 300; n++) step("R9 after reset");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_real_lines();
    t_small_frames();
    t_mode_midframe();
    t_mode_three();
    t_reset_mid();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule